// File: doc/BRIEF.md
# Two-Bank Page Translation Buffer with Fault Reporting

This block translates 32-bit virtual addresses into physical page frames for 8 KB pages. It holds two banks: one used by instruction fetches and one used by data reads and writes. Each bank is 4-way set associative with 16 sets. Every entry has two 32-bit words. The tag word carries the virtual page number and an 8-bit process tag. The attribute word carries the physical frame and five flag bits. Software fills entries through a one-cycle indexed write port.

A lookup request carries the address, the access kind, the user-mode flag, the current process ID, a configuration word that enables the individual checks, and a debug flag. One cycle later the block returns the hit flag, the frame, the granted permissions and an exception vector number. On a non-debug miss or protection fault it updates a select register and a cause register for the refill handler. A 16-bit LFSR proposes the way to refill, and it advances once per such event.

Top module: `tlb_xlate`

## Requirements
- R1: After reset all outputs are zero, the select and cause registers read zero, and the replacement LFSR holds 0xCCCC.
- R2: The access code on acc_i is 0 for read, 1 for write and 2 for execute. Execute uses the instruction bank and the other codes use the data bank. A response appears on the cycle after a request. An entry write (wr_data_tlb_i: 0 = instruction bank, 1 = data bank) takes effect one cycle after it is presented.
- R3: The set index is address bits 16:13. An entry matches when tag-word bits 31:13 equal address bits 31:13, and either attribute bit 4 (global) is set or tag-word bits 7:0 equal the current process ID.
- R4: If several ways match, the lowest-numbered way is used.
- R5: On a hit with no fault, hit_o is 1, pfn_o is attribute bits 31:13 and vec_o is the bank base (4 for instruction, 8 for data). perm_o has bit 0 (read) always set. Bit 1 (write) equals attribute bit 1. Bit 2 (execute) is set only in the instruction bank, and only when config bit 17 or attribute bit 0 is set.
- R6: On a miss, hit_o, pfn_o and perm_o are zero and vec_o is the bank base.
- R7: A matched entry with attribute bit 2 set faults with vector base+2 when config bit 18 and user_i are both set. This check wins over every other fault.
- R8: A write to an entry with attribute bit 1 clear faults with base+3 when config bit 19 is set. An execute to an entry with attribute bit 0 clear faults with base+3 when config bit 17 is set. These checks are made after the kernel check and before the valid check.
- R9: A matched entry with attribute bit 3 clear faults with base+1 only when config bit 16 is set. Otherwise it hits normally.
- R10: On a non-debug miss or fault, sel_o is rewritten: bits 3:0 take the set index, bits 5:4 take the way and all other bits are zero. The way is the matched way for a fault, and the LFSR low two bits, read before the step, for a miss.
- R11: On a non-debug miss or fault, cause_o bits 7:0 take the process ID, bits 9:8 take the access code and bits 31:13 take address bits 31:13. Bits 12:10 keep their value.
- R12: The LFSR steps exactly once per non-debug miss or fault. A step shifts it right by one and places the parity of (state AND 0x8805) into bit 15.
- R13: A debug lookup returns the same hit, frame, permission and vector results, and leaves the LFSR, sel_o and cause_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Entry write strobe |
| wr_data_tlb_i | input | 1 | Bank to write: 0 instruction, 1 data |
| wr_way_i | input | 2 | Way to write |
| wr_idx_i | input | 4 | Set to write |
| wr_hi_i | input | 32 | Tag word |
| wr_lo_i | input | 32 | Attribute word |
| req_i | input | 1 | Lookup request |
| vaddr_i | input | 32 | Virtual address |
| acc_i | input | 2 | Access code: 0 read, 1 write, 2 execute |
| user_i | input | 1 | User-mode access |
| pid_i | input | 8 | Current process ID |
| cfg_i | input | 32 | Check enables (bits 16 to 19) |
| debug_i | input | 1 | Debug lookup, no state update |
| rsp_valid_o | output | 1 | Response valid |
| hit_o | output | 1 | Translation granted |
| pfn_o | output | 19 | Physical frame number |
| perm_o | output | 3 | Granted permissions: bit 0 read, bit 1 write, bit 2 execute |
| vec_o | output | 4 | Exception vector number |
| sel_o | output | 32 | Refill select register |
| cause_o | output | 32 | Fault cause register |

## Verification
The assertions assume that an entry write and a lookup never fall in the same cycle, since that ordering is left undefined. They also assume that acc_i never carries code 3. The bench drives writes and requests in separate cycles and uses only the three defined access codes. It also avoids virtual page 0 with process ID 0, because those values would match the all-zero entries left by reset.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W      = 32;
  localparam int PAGE_SH   = 13;
  localparam int VPN_W     = VA_W - PAGE_SH;
  localparam int PID_W     = 8;
  localparam int LFSR_W    = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hCCCC;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'h8805;
  localparam int VEC_W     = 4;
  localparam logic [VEC_W-1:0] INSTR_BASE = 4'd4;
  localparam logic [VEC_W-1:0] DATA_BASE  = 4'd8;
  // attribute word flag positions
  localparam int LO_X = 0;
  localparam int LO_W = 1;
  localparam int LO_K = 2;
  localparam int LO_V = 3;
  localparam int LO_G = 4;
  // config check enables
  localparam int CFG_VCHK = 16;
  localparam int CFG_XCHK = 17;
  localparam int CFG_KCHK = 18;
  localparam int CFG_WCHK = 19;

  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2
  } acc_e;
endpackage

// File: rtl/tlb_bank.sv
module tlb_bank
  import tlb_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WAY_W-1:0] wway_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [31:0]      whi_i,
  input  logic [31:0]      wlo_i,
  input  logic [IDX_W-1:0] ridx_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PID_W-1:0] pid_i,
  output logic             match_o,
  output logic [WAY_W-1:0] way_o,
  output logic [31:0]      lo_o
);
  logic [31:0] hi_q [WAYS][SETS];
  logic [31:0] lo_q [WAYS][SETS];
  logic [WAYS-1:0] way_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++) begin
          hi_q[w][s] <= '0;
          lo_q[w][s] <= '0;
        end
    end else if (we_i) begin
      hi_q[wway_i][widx_i] <= whi_i;
      lo_q[wway_i][widx_i] <= wlo_i;
    end
  end

  for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
    logic [31:0] hi_e, lo_e;
    assign hi_e = hi_q[gw][ridx_i];
    assign lo_e = lo_q[gw][ridx_i];
    assign way_hit[gw] = (hi_e[31:PAGE_SH] == vpn_i) &&
                         (lo_e[LO_G] || (hi_e[PID_W-1:0] == pid_i));
  end

  // lowest way wins
  always_comb begin
    match_o = |way_hit;
    way_o   = '0;
    lo_o    = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        way_o = WAY_W'(w);
        lo_o  = lo_q[w][ridx_i];
      end
    end
  end

  // R2
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (hi_q[$past(wway_i)][$past(widx_i)] == $past(whi_i)) &&
             (lo_q[$past(wway_i)][$past(widx_i)] == $past(wlo_i)));
endmodule

// File: rtl/tlb_prot.sv
module tlb_prot
  import tlb_pkg::*;
(
  input  logic [31:0] lo_i,
  input  logic [31:0] cfg_i,
  input  acc_e        acc_i,
  input  logic        user_i,
  input  logic        instr_i,
  output logic        fault_o,
  output logic [1:0]  off_o,
  output logic [2:0]  perm_o
);
  always_comb begin
    fault_o = 1'b1;
    off_o   = 2'd0;
    if (cfg_i[CFG_KCHK] && lo_i[LO_K] && user_i)
      off_o = 2'd2;
    else if (acc_i == ACC_WR && cfg_i[CFG_WCHK] && !lo_i[LO_W])
      off_o = 2'd3;
    else if (acc_i == ACC_EX && cfg_i[CFG_XCHK] && !lo_i[LO_X])
      off_o = 2'd3;
    else if (cfg_i[CFG_VCHK] && !lo_i[LO_V])
      off_o = 2'd1;
    else
      fault_o = 1'b0;
    perm_o = fault_o ? 3'b000 :
             {instr_i && (cfg_i[CFG_XCHK] || lo_i[LO_X]), lo_i[LO_W], 1'b1};
  end
endmodule

// File: rtl/tlb_lfsr.sv
module tlb_lfsr
  import tlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [LFSR_W-1:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_o <= LFSR_SEED;
    else if (step_i) state_o <= {^(state_o & LFSR_TAPS), state_o[LFSR_W-1:1]};
  end

  // R12
  lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state_o));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NUM_TLB = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_data_tlb_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_hi_i,
  input  logic [31:0]      wr_lo_i,
  input  logic             req_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [1:0]       acc_i,
  input  logic             user_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic [31:0]      cfg_i,
  input  logic             debug_i,
  output logic             rsp_valid_o,
  output logic             hit_o,
  output logic [VPN_W-1:0] pfn_o,
  output logic [2:0]       perm_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [31:0]      sel_o,
  output logic [31:0]      cause_o
);
  acc_e             acc;
  logic             instr;
  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] idx;
  logic             bk_match [NUM_TLB];
  logic [WAY_W-1:0] bk_way   [NUM_TLB];
  logic [31:0]      bk_lo    [NUM_TLB];
  logic             m_match;
  logic [WAY_W-1:0] m_way;
  logic [31:0]      m_lo;
  logic             fault;
  logic [1:0]       off;
  logic [2:0]       perm;
  logic             good, upd;
  logic [VEC_W-1:0] vec_nxt;
  logic [WAY_W-1:0] refill_way;
  logic [LFSR_W-1:0] lfsr;

  assign acc   = acc_e'(acc_i);
  assign instr = (acc == ACC_EX);
  assign vpn   = vaddr_i[VA_W-1:PAGE_SH];
  assign idx   = vpn[IDX_W-1:0];

  for (genvar gt = 0; gt < NUM_TLB; gt++) begin : g_tlb
    tlb_bank #(.WAYS(WAYS), .SETS(SETS)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_en_i && (wr_data_tlb_i == 1'(gt))),
      .wway_i (wr_way_i),
      .widx_i (wr_idx_i),
      .whi_i  (wr_hi_i),
      .wlo_i  (wr_lo_i),
      .ridx_i (idx),
      .vpn_i  (vpn),
      .pid_i  (pid_i),
      .match_o(bk_match[gt]),
      .way_o  (bk_way[gt]),
      .lo_o   (bk_lo[gt])
    );
  end

  // bank 0 serves fetches, bank 1 serves data
  assign m_match = instr ? bk_match[0] : bk_match[1];
  assign m_way   = instr ? bk_way[0]   : bk_way[1];
  assign m_lo    = instr ? bk_lo[0]    : bk_lo[1];

  tlb_prot u_prot (
    .lo_i   (m_lo),
    .cfg_i  (cfg_i),
    .acc_i  (acc),
    .user_i (user_i),
    .instr_i(instr),
    .fault_o(fault),
    .off_o  (off),
    .perm_o (perm)
  );

  assign good       = m_match && !fault;
  assign vec_nxt    = (instr ? INSTR_BASE : DATA_BASE) + (m_match ? VEC_W'(off) : '0);
  assign upd        = req_i && !good && !debug_i;
  assign refill_way = m_match ? m_way : lfsr[WAY_W-1:0];

  tlb_lfsr u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (upd),
    .state_o(lfsr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      pfn_o       <= '0;
      perm_o      <= '0;
      vec_o       <= '0;
      sel_o       <= '0;
      cause_o     <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        hit_o  <= good;
        pfn_o  <= good ? m_lo[31:PAGE_SH] : '0;
        perm_o <= good ? perm : 3'b000;
        vec_o  <= vec_nxt;
      end
      if (upd) begin
        sel_o                        <= 32'({refill_way, idx});
        cause_o[PID_W-1:0]           <= pid_i;
        cause_o[9:8]                 <= acc_i;
        cause_o[VA_W-1:PAGE_SH]      <= vpn;
      end
    end
  end

  // R2
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  // R6
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !hit_o |-> perm_o == 3'b000 && pfn_o == '0);
  // R5
  hit_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && hit_o |-> perm_o[0]);
  // R5
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> vec_o >= INSTR_BASE && vec_o <= DATA_BASE + 4'd3);
  // R13
  debug_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && debug_i |=> $stable(sel_o) && $stable(cause_o));
  // R11
  cause_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(cause_o[12:10]));
  // R10
  sel_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !debug_i |=> hit_o ||
      sel_o[IDX_W-1:0] == $past(vaddr_i[PAGE_SH+IDX_W-1:PAGE_SH]));
endmodule

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/100ps
module tlb_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_dt = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_hi = '0, wr_lo = '0;
  logic        req = 1'b0, usr = 1'b0, dbg = 1'b0;
  logic [31:0] va = '0, cfg = '0;
  logic [1:0]  acc = '0;
  logic [7:0]  pid = '0;
  logic        rsp_valid, hit;
  logic [18:0] pfn;
  logic [2:0]  perm;
  logic [3:0]  vec;
  logic [31:0] sel, cause;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [15:0] lfsr_m = 16'hCCCC;
  logic [31:0] sel_m = '0, cause_m = '0;

  always #2.5 clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_tlb_i(wr_dt), .wr_way_i(wr_way), .wr_idx_i(wr_idx),
    .wr_hi_i(wr_hi), .wr_lo_i(wr_lo),
    .req_i(req), .vaddr_i(va), .acc_i(acc), .user_i(usr), .pid_i(pid),
    .cfg_i(cfg), .debug_i(dbg),
    .rsp_valid_o(rsp_valid), .hit_o(hit), .pfn_o(pfn), .perm_o(perm),
    .vec_o(vec), .sel_o(sel), .cause_o(cause)
  );

  localparam logic [31:0] C_V = 32'h1 << 16, C_X = 32'h1 << 17,
                          C_K = 32'h1 << 18, C_W = 32'h1 << 19;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hi(logic [18:0] vpn, logic [7:0] p);
    return {vpn, 5'b0, p};
  endfunction
  // flags: {g,v,k,w,x}
  function automatic logic [31:0] mk_lo(logic [18:0] f, logic [4:0] flags);
    return {f, 8'b0, flags};
  endfunction

  function automatic logic [15:0] lfsr_step(logic [15:0] s);
    int n = 0;
    logic [15:0] t = s & 16'h8805;
    for (int i = 0; i < 16; i++) if (t[i]) n++;
    return {1'(n % 2), s[15:1]};
  endfunction

  task automatic wr(logic dt, logic [1:0] w, logic [3:0] i, logic [31:0] h, logic [31:0] l);
    @(negedge clk);
    wr_en = 1; wr_dt = dt; wr_way = w; wr_idx = i; wr_hi = h; wr_lo = l;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(string tag, logic [18:0] vp, logic [1:0] a, logic u,
                        logic [7:0] p, logic [31:0] c, logic d,
                        logic e_hit, logic [18:0] e_pfn, logic [2:0] e_perm,
                        logic [3:0] e_vec, int e_way);
    logic [1:0] way;
    @(negedge clk);
    req = 1; va = {vp, 13'h0A5}; acc = a; usr = u; pid = p; cfg = c; dbg = d;
    @(negedge clk);
    req = 0;
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " hit"}, 32'(hit), 32'(e_hit));
    chk({tag, " pfn"}, 32'(pfn), 32'(e_pfn));
    chk({tag, " perm"}, 32'(perm), 32'(e_perm));
    chk({tag, " vec"}, 32'(vec), 32'(e_vec));
    if (!e_hit && !d) begin
      way = (e_way < 0) ? lfsr_m[1:0] : 2'(e_way);
      sel_m = {26'b0, way, vp[3:0]};
      cause_m = {vp, cause_m[12:10], a, p};
      lfsr_m = lfsr_step(lfsr_m);
    end
    chk({tag, " sel"}, sel, sel_m);
    chk({tag, " cause"}, cause, cause_m);
  endtask

  task automatic t_reset();
    chk("R1 valid", 32'(rsp_valid), 0);
    chk("R1 hit", 32'(hit), 0);
    chk("R1 vec", 32'(vec), 0);
    chk("R1 sel", sel, 0);
    chk("R1 cause", cause, 0);
  endtask

  task automatic t_miss();
    lookup("R1 R12 R6 refill way from seed", 19'h11, 2'd0, 0, 8'h05, 0, 0, 0, 0, 0, 4'd8, -1);
    lookup("R12 R10 second refill", 19'h21, 2'd1, 0, 8'h05, 0, 0, 0, 0, 0, 4'd8, -1);
    lookup("R2 R11 fetch miss", 19'h31, 2'd2, 0, 8'h07, 0, 0, 0, 0, 0, 4'd4, -1);
  endtask

  task automatic t_hit();
    wr(1, 2'd2, 4'd1, mk_hi(19'h11, 8'h05), mk_lo(19'h123, 5'b01010));
    lookup("R3 R5 pid hit", 19'h11, 2'd0, 0, 8'h05, 0, 0, 1, 19'h123, 3'b011, 4'd8, 0);
    lookup("R3 pid mismatch", 19'h11, 2'd0, 0, 8'h06, 0, 0, 0, 0, 0, 4'd8, -1);
    wr(1, 2'd1, 4'd2, mk_hi(19'h12, 8'h09), mk_lo(19'h456, 5'b11000));
    lookup("R3 global hit", 19'h12, 2'd0, 0, 8'h03, 0, 0, 1, 19'h456, 3'b001, 4'd8, 0);
    lookup("R2 fetch misses data entry", 19'h12, 2'd2, 0, 8'h03, 0, 0, 0, 0, 0, 4'd4, -1);
  endtask

  task automatic t_first();
    wr(1, 2'd3, 4'd4, mk_hi(19'h14, 8'h05), mk_lo(19'h00B, 5'b01000));
    wr(1, 2'd0, 4'd4, mk_hi(19'h14, 8'h05), mk_lo(19'h00A, 5'b01000));
    lookup("R4 lowest way wins", 19'h14, 2'd0, 0, 8'h05, 0, 0, 1, 19'h00A, 3'b001, 4'd8, 0);
  endtask

  task automatic t_kernel();
    wr(1, 2'd3, 4'd5, mk_hi(19'h15, 8'h05), mk_lo(19'h055, 5'b01100));
    lookup("R7 kernel fault", 19'h15, 2'd0, 1, 8'h05, C_K, 0, 0, 0, 0, 4'd10, 3);
    lookup("R7 kernel mode ok", 19'h15, 2'd0, 0, 8'h05, C_K, 0, 1, 19'h055, 3'b001, 4'd8, 0);
    lookup("R7 kernel over write", 19'h15, 2'd1, 1, 8'h05, C_K | C_W, 0, 0, 0, 0, 4'd10, 3);
    lookup("R8 write fault", 19'h15, 2'd1, 0, 8'h05, C_W, 0, 0, 0, 0, 4'd11, 3);
    lookup("R8 write check off", 19'h15, 2'd1, 0, 8'h05, 0, 0, 1, 19'h055, 3'b001, 4'd8, 0);
  endtask

  task automatic t_exec();
    wr(0, 2'd1, 4'd6, mk_hi(19'h16, 8'h05), mk_lo(19'h066, 5'b01000));
    lookup("R8 exec fault", 19'h16, 2'd2, 0, 8'h05, C_X, 0, 0, 0, 0, 4'd7, 1);
    lookup("R5 no exec grant", 19'h16, 2'd2, 0, 8'h05, 0, 0, 1, 19'h066, 3'b001, 4'd4, 0);
    wr(0, 2'd2, 4'd7, mk_hi(19'h17, 8'h05), mk_lo(19'h077, 5'b01011));
    lookup("R5 exec grant", 19'h17, 2'd2, 0, 8'h05, 0, 0, 1, 19'h077, 3'b111, 4'd4, 0);
    wr(1, 2'd0, 4'd8, mk_hi(19'h18, 8'h05), mk_lo(19'h088, 5'b01001));
    lookup("R5 data never exec", 19'h18, 2'd0, 0, 8'h05, C_X, 0, 1, 19'h088, 3'b001, 4'd8, 0);
  endtask

  task automatic t_invalid();
    wr(1, 2'd1, 4'd9, mk_hi(19'h19, 8'h05), mk_lo(19'h099, 5'b00000));
    lookup("R9 invalid fault", 19'h19, 2'd0, 0, 8'h05, C_V, 0, 0, 0, 0, 4'd9, 1);
    lookup("R9 valid check off", 19'h19, 2'd0, 0, 8'h05, 0, 0, 1, 19'h099, 3'b001, 4'd8, 0);
    lookup("R8 write over invalid", 19'h19, 2'd1, 0, 8'h05, C_V | C_W, 0, 0, 0, 0, 4'd11, 1);
  endtask

  task automatic t_debug();
    lookup("R13 debug miss", 19'h3A, 2'd0, 0, 8'h05, 0, 1, 0, 0, 0, 4'd8, -1);
    lookup("R13 debug fault", 19'h15, 2'd0, 1, 8'h05, C_K, 1, 0, 0, 0, 4'd10, 3);
    lookup("R13 R12 lfsr unchanged", 19'h3A, 2'd0, 0, 8'h05, 0, 0, 0, 0, 0, 4'd8, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_miss();
    t_hit();
    t_first();
    t_kernel();
    t_exec();
    t_invalid();
    t_debug();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule